// File: doc/BRIEF.md
# Snooping Three-State Coherent Cache Cluster

This block keeps a small set of private caches coherent over one shared, single-transaction bus. Each cache is a direct-mapped array of one-word lines. Its controller serves its own core's reads and writes, and it watches every transaction that another cache puts on the bus. Each line is held invalid, shared (read permission only) or modified (the only valid copy, and writable). A fixed-priority arbiter serializes the bus, so every cache observes the same order of transactions.

A request that a cache cannot finish locally becomes a bus transaction. The transaction is a read when the core only wants to read. It is a read-for-ownership when the core wants to write. It is a write-back when a modified victim must leave first. Whole bus cycles complete in one clock. A cache holding the addressed line modified supplies the data in place of memory and writes it through to memory in the same cycle. Otherwise the word comes from the memory model inside the cluster.

Top module: `msi_coherent_cluster`

## Requirements
- R1: After reset every line is invalid, `core_done`, `bus_valid` and `bus_grant` are low, and memory word `a` holds `a XOR MEM_SEED` (seed 0x5A by default), so the first access to any address is a miss that returns that value.
- R2: A read miss puts one read transaction (`bus_op` = 1) on the bus. When no cache owns the line, memory supplies it (`bus_supplied` = 0). The line is installed shared, so a repeated read by the same core causes no bus traffic.
- R3: A cache holding a line shared leaves it unchanged when another cache reads it, so both caches then read that line with no bus transaction.
- R4: A core write to a line held shared issues a read-for-ownership (`bus_op` = 2) before it completes, and the line becomes modified.
- R5: A core write to a line already held modified completes with no bus transaction.
- R6: A cache that observes another cache's read-for-ownership of a line it holds invalidates it, so its next access to that address misses.
- R7: A cache holding a line modified answers another cache's read or read-for-ownership itself. It raises `bus_supplied`, places its word on `bus_data` and writes the word to memory in the same cycle. On a read it keeps the line shared.
- R8: A miss whose line slot holds a different modified address first issues a write-back (`bus_op` = 3) carrying the victim address and its latest data. Only then is the fill issued.
- R9: At most one cache is granted the bus per cycle, and among requesting caches the lowest index wins.
- R10: Every read returns the value of the most recent write to that address by any core, or the reset value if the address was never written.
- R11: Each request is acknowledged by a one-cycle `core_done` pulse. Read data is valid on `core_rdata` in that cycle. A fill ends one cycle after its bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req_valid | input | NCORE | Per-core request, held until its done pulse |
| core_req_write | input | NCORE | Per-core request kind: 1 write, 0 read |
| core_req_addr | input | NCORE*ADDR_W | Per-core word address, core i at bits i*ADDR_W |
| core_req_wdata | input | NCORE*DATA_W | Per-core write data |
| core_done | output | NCORE | One-cycle completion pulse per core |
| core_rdata | output | NCORE*DATA_W | Per-core read data, valid with done |
| bus_valid | output | 1 | A transaction occupies the bus this cycle |
| bus_op | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Address of the current transaction |
| bus_data | output | DATA_W | Data carried by the current transaction |
| bus_supplied | output | 1 | A cache, not memory, supplied `bus_data` |
| bus_grant | output | NCORE | One-hot owner of the current transaction |

## Verification
The checker takes for granted that a core keeps its request valid, with an unchanged address, kind and data, until its done pulse. It also takes for granted that the core drops the request in the done cycle. The bench drives every request this way, one task per request. It releases the inputs at the falling edge where the pulse is seen, and it raises the next request no earlier than one cycle later. Apart from one test with both cores raising requests together, requests are issued one at a time. This lets the bench derive each expected bus transaction from its own model of line states.

// File: rtl/msi_pkg.sv
// Package msi_pkg: shared encodings for the snooping cache cluster.
// Assumes: two-bit codes are visible on the bus and decoded by every cache.
package msi_pkg;

    // Per-line coherence state.
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_state_t;

    // Bus transaction kind; codes are visible on the bus_op port.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_OWN   = 2'd2,
        OP_EVICT = 2'd3
    } bus_op_t;

    // Controller sequencing state.
    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_BUS  = 2'd1,
        CT_RESP = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/msi_prio_arbiter.sv
// Module msi_prio_arbiter: combinational fixed-priority grant, index 0 highest.
// Assumes: requests are held until granted; one grant per cycle.
module msi_prio_arbiter #(
    parameter int NREQ = 2
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant
);

    // Grant the lowest-indexed active request.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msi_memory.sv
// Module msi_memory: word memory model behind the bus, asynchronous read,
// synchronous write. Reset fills word a with a XOR SEED.
// Assumes: at most one write per cycle, issued by the bus logic.
module msi_memory #(
    parameter int                ADDR_W = 6,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] SEED   = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Initialise or update the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                words[a] <= DATA_W'(a) ^ SEED;
            end
        end else if (wr_en) begin
            words[addr] <= wr_data;
        end
    end

    // Present the addressed word.
    assign rd_data = words[addr];

endmodule

// File: rtl/msi_cache_ctrl.sv
// Module msi_cache_ctrl: one direct-mapped cache with its three-state
// coherence controller. Serves core requests, requests the bus for misses,
// upgrades and victim write-backs, and snoops other caches' transactions.
// Assumes: the bus completes a granted transaction in the same cycle;
// the core holds its request stable until done.
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output bus_op_t           bus_op_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_grant_i,
    input  logic              bus_valid_i,
    input  bus_op_t           bus_op_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              snoop_supply,
    output logic [DATA_W-1:0] snoop_data
);

    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    line_state_t       st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];
    ctl_state_t        ctl_q;

    logic [IDX_W-1:0] rq_idx;
    logic [TAG_W-1:0] rq_tag;
    logic             rq_tag_eq;
    logic             rq_present;
    logic [IDX_W-1:0] sn_idx;
    logic [TAG_W-1:0] sn_tag;
    logic             sn_match;

    // Split the core address and look up its line.
    always_comb begin
        rq_idx     = req_addr[IDX_W-1:0];
        rq_tag     = req_addr[ADDR_W-1:IDX_W];
        rq_tag_eq  = (tag_q[rq_idx] == rq_tag);
        rq_present = rq_tag_eq && (st_q[rq_idx] != LN_INV);
    end

    // Choose the transaction to request: victim write-back first, then the fill.
    always_comb begin
        bus_req = (ctl_q == CT_BUS);
        if (st_q[rq_idx] == LN_MOD && !rq_tag_eq) begin
            bus_op_o   = OP_EVICT;
            bus_addr_o = {tag_q[rq_idx], rq_idx};
            bus_data_o = dat_q[rq_idx];
        end else begin
            bus_op_o   = req_write ? OP_OWN : OP_READ;
            bus_addr_o = req_addr;
            bus_data_o = '0;
        end
    end

    // Snoop: match another cache's transaction against the local array.
    always_comb begin
        sn_idx       = bus_addr_i[IDX_W-1:0];
        sn_tag       = bus_addr_i[ADDR_W-1:IDX_W];
        sn_match     = bus_valid_i && !bus_grant_i &&
                       (st_q[sn_idx] != LN_INV) && (tag_q[sn_idx] == sn_tag);
        snoop_supply = sn_match && (st_q[sn_idx] == LN_MOD) &&
                       (bus_op_i == OP_READ || bus_op_i == OP_OWN);
        snoop_data   = dat_q[sn_idx];
    end

    // Sequence core requests and update line state from own and snooped traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
            ctl_q <= CT_IDLE;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (sn_match) begin
                if (bus_op_i == OP_OWN) begin
                    st_q[sn_idx] <= LN_INV;
                end else if (bus_op_i == OP_READ && st_q[sn_idx] == LN_MOD) begin
                    st_q[sn_idx] <= LN_SHR;
                end
            end
            case (ctl_q)
                CT_IDLE: begin
                    if (req_valid) begin
                        if (rq_present && !req_write) begin
                            rdata <= dat_q[rq_idx];
                            done  <= 1'b1;
                            ctl_q <= CT_RESP;
                        end else if (rq_present && st_q[rq_idx] == LN_MOD) begin
                            dat_q[rq_idx] <= req_wdata;
                            done          <= 1'b1;
                            ctl_q         <= CT_RESP;
                        end else begin
                            ctl_q <= CT_BUS;
                        end
                    end
                end
                CT_BUS: begin
                    if (bus_grant_i) begin
                        case (bus_op_o)
                            OP_EVICT: st_q[rq_idx] <= LN_INV;
                            OP_READ: begin
                                st_q[rq_idx]  <= LN_SHR;
                                tag_q[rq_idx] <= rq_tag;
                                dat_q[rq_idx] <= bus_data_i;
                                rdata         <= bus_data_i;
                                done          <= 1'b1;
                                ctl_q         <= CT_RESP;
                            end
                            OP_OWN: begin
                                st_q[rq_idx]  <= LN_MOD;
                                tag_q[rq_idx] <= rq_tag;
                                dat_q[rq_idx] <= req_wdata;
                                done          <= 1'b1;
                                ctl_q         <= CT_RESP;
                            end
                            default: ;
                        endcase
                    end
                end
                default: ctl_q <= CT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msi_coherent_cluster.sv
// Module msi_coherent_cluster: NCORE snooping caches, a fixed-priority bus
// arbiter and the memory model on one single-cycle shared bus.
// Assumes: at most one cache holds a given line modified (kept by the protocol).
module msi_coherent_cluster
    import msi_pkg::*;
#(
    parameter int                NCORE    = 2,
    parameter int                ADDR_W   = 6,
    parameter int                DATA_W   = 8,
    parameter int                IDX_W    = 2,
    parameter logic [DATA_W-1:0] MEM_SEED = 8'h5A
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORE-1:0]        core_req_valid,
    input  logic [NCORE-1:0]        core_req_write,
    input  logic [NCORE*ADDR_W-1:0] core_req_addr,
    input  logic [NCORE*DATA_W-1:0] core_req_wdata,
    output logic [NCORE-1:0]        core_done,
    output logic [NCORE*DATA_W-1:0] core_rdata,
    output logic                    bus_valid,
    output logic [1:0]              bus_op,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_data,
    output logic                    bus_supplied,
    output logic [NCORE-1:0]        bus_grant
);

    logic [NCORE-1:0]  arb_req;
    bus_op_t           op_req   [NCORE];
    logic [ADDR_W-1:0] addr_req [NCORE];
    logic [DATA_W-1:0] data_req [NCORE];
    logic [NCORE-1:0]  sup_vec;
    logic [DATA_W-1:0] sup_dat  [NCORE];

    bus_op_t           cur_op;
    logic [DATA_W-1:0] wb_data;
    logic [DATA_W-1:0] sup_data;
    logic [DATA_W-1:0] mem_rd;
    logic              mem_wr;
    logic [DATA_W-1:0] mem_wdata;

    msi_prio_arbiter #(.NREQ(NCORE)) u_arb (
        .req   (arb_req),
        .grant (bus_grant)
    );

    // One controller per core.
    for (genvar g = 0; g < NCORE; g++) begin : g_cache
        msi_cache_ctrl #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) u_ctrl (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_valid    (core_req_valid[g]),
            .req_write    (core_req_write[g]),
            .req_addr     (core_req_addr[g*ADDR_W +: ADDR_W]),
            .req_wdata    (core_req_wdata[g*DATA_W +: DATA_W]),
            .done         (core_done[g]),
            .rdata        (core_rdata[g*DATA_W +: DATA_W]),
            .bus_req      (arb_req[g]),
            .bus_op_o     (op_req[g]),
            .bus_addr_o   (addr_req[g]),
            .bus_data_o   (data_req[g]),
            .bus_grant_i  (bus_grant[g]),
            .bus_valid_i  (bus_valid),
            .bus_op_i     (cur_op),
            .bus_addr_i   (bus_addr),
            .bus_data_i   (bus_data),
            .snoop_supply (sup_vec[g]),
            .snoop_data   (sup_dat[g])
        );
    end

    // Route the granted cache's request onto the bus.
    always_comb begin
        cur_op   = OP_NONE;
        bus_addr = '0;
        wb_data  = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (bus_grant[i]) begin
                cur_op   = op_req[i];
                bus_addr = addr_req[i];
                wb_data  = data_req[i];
            end
        end
    end

    // Collect the owner's data when a snooping cache supplies it.
    always_comb begin
        sup_data = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (sup_vec[i]) sup_data = sup_data | sup_dat[i];
        end
    end

    // Resolve bus data and the memory update for this transaction.
    always_comb begin
        bus_valid    = |bus_grant;
        bus_op       = cur_op;
        bus_supplied = |sup_vec;
        mem_wr       = bus_valid && (cur_op == OP_EVICT || bus_supplied);
        mem_wdata    = (cur_op == OP_EVICT) ? wb_data : sup_data;
        if (cur_op == OP_EVICT)  bus_data = wb_data;
        else if (bus_supplied)   bus_data = sup_data;
        else                     bus_data = mem_rd;
    end

    msi_memory #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEED   (MEM_SEED)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_wr),
        .addr    (bus_addr),
        .wr_data (mem_wdata),
        .rd_data (mem_rd)
    );

endmodule

// File: rtl/msi_cluster_checker.sv
// Module msi_cluster_checker: protocol and interface properties of the
// cluster, bound to msi_coherent_cluster.
// Assumes: cores hold requests stable until done (checked here too).
module msi_cluster_checker #(
    parameter int NCORE  = 2,
    parameter int ADDR_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NCORE-1:0]        core_req_valid,
    input logic [NCORE*ADDR_W-1:0] core_req_addr,
    input logic [NCORE-1:0]        core_done,
    input logic                    bus_valid,
    input logic [1:0]              bus_op,
    input logic                    bus_supplied,
    input logic [NCORE-1:0]        bus_grant,
    input logic [NCORE-1:0]        arb_req
);

    // R9: a single owner per bus cycle.
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));

    // R2: an occupied bus always carries a real transaction kind.
    assert_bus_op_defined_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_op != 2'd0);

    // R7: only fills can be answered by a cache, never write-backs.
    assert_supply_on_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_supplied |-> (bus_valid && (bus_op == 2'd1 || bus_op == 2'd2)));

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        // R9: a grant goes only to a requester with no lower-index requester.
        assert_grant_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bus_grant[i] |-> (arb_req[i] && ((arb_req & ((1 << i) - 1)) == '0)));

        // R11: done lasts exactly one cycle.
        assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[i] |=> !core_done[i]);

        // R11: a granted fill completes in the following cycle.
        assert_fill_completes_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_grant[i] && bus_op != 2'd3) |=> core_done[i]);

        // R11: input rule, a pending request stays up until done.
        assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (core_req_valid[i] && !core_done[i]) |=> (core_req_valid[i] || core_done[i]));

        // R11: input rule, a pending request keeps its address.
        assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (core_req_valid[i] && !core_done[i]) |=>
                ($stable(core_req_addr[i*ADDR_W +: ADDR_W]) || core_done[i]));
    end

endmodule

bind msi_coherent_cluster msi_cluster_checker #(
    .NCORE  (NCORE),
    .ADDR_W (ADDR_W)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_req_valid (core_req_valid),
    .core_req_addr  (core_req_addr),
    .core_done      (core_done),
    .bus_valid      (bus_valid),
    .bus_op         (bus_op),
    .bus_supplied   (bus_supplied),
    .bus_grant      (bus_grant),
    .arb_req        (arb_req)
);

// File: tb/msi_coherent_cluster_test.sv
`timescale 1ns/1ps
// Bench: two caches on the shared bus; sweeps every core, kind and address
// of a small set, then a pseudo-random run, checked against a line-state model.
module msi_coherent_cluster_test;

    localparam int NC = 2;
    localparam int AW = 6;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    core_req_valid = '0;
    logic [NC-1:0]    core_req_write = '0;
    logic [NC*AW-1:0] core_req_addr = '0;
    logic [NC*DW-1:0] core_req_wdata = '0;
    logic [NC-1:0]    core_done;
    logic [NC*DW-1:0] core_rdata;
    logic             bus_valid;
    logic [1:0]       bus_op;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_data;
    logic             bus_supplied;
    logic [NC-1:0]    bus_grant;

    int checks = 0;
    int fails  = 0;

    // Bench model: per-cache line state (0 I, 1 S, 2 M), tags, invalidation marks.
    int        mdl_st  [NC][4];
    logic [3:0] mdl_tag [NC][4];
    bit        mdl_inv [NC][4];
    logic [7:0] golden  [64];

    // Transactions observed during one request.
    int         n_seen;
    logic [1:0] s_op   [4];
    logic [5:0] s_addr [4];
    bit         s_sup  [4];
    logic [7:0] s_data [4];

    always #2.5 clk = ~clk;

    msi_coherent_cluster uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_req_valid (core_req_valid),
        .core_req_write (core_req_write),
        .core_req_addr  (core_req_addr),
        .core_req_wdata (core_req_wdata),
        .core_done      (core_done),
        .core_rdata     (core_rdata),
        .bus_valid      (bus_valid),
        .bus_op         (bus_op),
        .bus_addr       (bus_addr),
        .bus_data       (bus_data),
        .bus_supplied   (bus_supplied),
        .bus_grant      (bus_grant)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < 4; i++) begin
                mdl_st[c][i]  = 0;
                mdl_tag[c][i] = '0;
                mdl_inv[c][i] = 1'b0;
            end
        end
        for (int a = 0; a < 64; a++) golden[a] = 8'(a) ^ 8'h5A;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        core_req_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_model();
    endtask

    // One request from core c; compare against the model's expectations.
    task automatic run_op(input int c, input bit wr, input logic [5:0] a,
                          input logic [7:0] wd);
        int         idx;
        int         o;
        int         st;
        int         en;
        int         cyc;
        bit         tmatch;
        bit         hitm;
        bit         got;
        string      rq;
        logic [1:0] eop  [2];
        logic [5:0] ead  [2];
        bit         esup [2];
        logic [7:0] edat [2];
        logic [7:0] erd;
        logic [7:0] rd;
        idx    = int'(a[1:0]);
        o      = 1 - c;
        st     = mdl_st[c][idx];
        tmatch = (mdl_tag[c][idx] == a[5:2]);
        hitm   = tmatch && st != 0;
        en     = 0;
        rq     = "R2";
        erd    = golden[a];
        rd     = '0;
        if (hitm && !wr) begin
            rq = "R3";
        end else if (hitm && st == 2) begin
            rq = "R5";
        end else begin
            if (st == 2 && !tmatch) begin
                eop[0]  = 2'd3;
                ead[0]  = {mdl_tag[c][idx], a[1:0]};
                esup[0] = 1'b0;
                edat[0] = golden[{mdl_tag[c][idx], a[1:0]}];
                en      = 1;
            end
            eop[en]  = wr ? 2'd2 : 2'd1;
            ead[en]  = a;
            esup[en] = (mdl_st[o][idx] == 2) && (mdl_tag[o][idx] == a[5:2]);
            edat[en] = golden[a];
            if (en == 1)                        rq = "R8";
            else if (esup[en])                  rq = "R7";
            else if (mdl_inv[c][idx] && tmatch) rq = "R6";
            else if (wr && hitm)                rq = "R4";
            else                                rq = "R2";
            en++;
            if (mdl_st[o][idx] != 0 && mdl_tag[o][idx] == a[5:2]) begin
                if (wr) begin
                    mdl_st[o][idx]  = 0;
                    mdl_inv[o][idx] = 1'b1;
                end else if (mdl_st[o][idx] == 2) begin
                    mdl_st[o][idx] = 1;
                end
            end
            mdl_st[c][idx]  = wr ? 2 : 1;
            mdl_tag[c][idx] = a[5:2];
            mdl_inv[c][idx] = 1'b0;
        end
        if (wr) golden[a] = wd;

        @(negedge clk);
        core_req_valid[c] = 1'b1;
        core_req_write[c] = wr;
        core_req_addr[c*AW +: AW]  = a;
        core_req_wdata[c*DW +: DW] = wd;
        n_seen = 0;
        got = 1'b0;
        cyc = 0;
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (bus_valid && n_seen < 4) begin
                s_op[n_seen]   = bus_op;
                s_addr[n_seen] = bus_addr;
                s_sup[n_seen]  = bus_supplied;
                s_data[n_seen] = bus_data;
                n_seen++;
            end
            if (core_done[c]) begin
                got = 1'b1;
                rd  = core_rdata[c*DW +: DW];
                core_req_valid[c] = 1'b0;
            end
        end
        chk(got, "R11", "done seen", int'(got), 1);
        chk(n_seen == en, rq, "transaction count", n_seen, en);
        for (int k = 0; k < en && k < n_seen; k++) begin
            chk(s_op[k] == eop[k], rq, "bus_op", s_op[k], eop[k]);
            chk(s_addr[k] == ead[k], rq, "bus_addr", s_addr[k], ead[k]);
            chk(s_sup[k] == esup[k], rq, "bus_supplied", s_sup[k], esup[k]);
            chk(s_data[k] == edat[k], rq, "bus_data", s_data[k], edat[k]);
        end
        if (!wr) chk(rd == erd, "R10", "read data", rd, erd);
        @(negedge clk);
        chk(core_done[c] == 1'b0, "R11", "done width", core_done[c], 0);
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] x;
        int          c0done;
        int          c1done;
        int          cyc;
        int          nb;
        logic [1:0]  gseq [2];
        bit          sseq [2];
        logic [7:0]  dseq [2];

        do_reset();
        @(negedge clk);
        // R1: quiet outputs after reset.
        chk(core_done == '0, "R1", "core_done after reset", core_done, 0);
        chk(bus_valid == 1'b0, "R1", "bus_valid after reset", bus_valid, 0);
        chk(bus_grant == '0, "R1", "bus_grant after reset", bus_grant, 0);

        // Directed opening: R1 cold miss, R2 refetch hit, R3 shared reader, R4, R5, R7, R6, R8.
        run_op(0, 1'b0, 6'h05, 8'h00);
        run_op(0, 1'b0, 6'h05, 8'h00);
        run_op(1, 1'b0, 6'h05, 8'h00);
        run_op(0, 1'b0, 6'h05, 8'h00);
        run_op(0, 1'b1, 6'h05, 8'hC3);
        run_op(0, 1'b1, 6'h05, 8'h3C);
        run_op(1, 1'b0, 6'h05, 8'h00);
        run_op(1, 1'b1, 6'h05, 8'h77);
        run_op(0, 1'b0, 6'h05, 8'h00);
        run_op(1, 1'b1, 6'h09, 8'h99);
        run_op(1, 1'b0, 6'h05, 8'h00);

        // Sweep: every pass, core, kind, tag 0..2 and index.
        for (int p = 0; p < 3; p++)
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < 2; w++)
                    for (int t = 0; t < 3; t++)
                        for (int i = 0; i < 4; i++)
                            run_op(c, w[0], 6'(t * 4 + i), 8'((t * 4 + i) * 7 + p * 13 + c));

        // Pseudo-random mixed traffic.
        x = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            run_op(int'(x[0]), x[1], 6'((x[9:8] % 3) * 4 + x[3:2]), x[23:16]);
        end

        // R9: simultaneous writes to one line from both cores after a fresh reset.
        do_reset();
        @(negedge clk);
        core_req_valid = 2'b11;
        core_req_write = 2'b11;
        core_req_addr  = {6'h2D, 6'h2D};
        core_req_wdata = {8'h22, 8'h11};
        c0done = 0;
        c1done = 0;
        cyc = 0;
        nb = 0;
        while ((c0done == 0 || c1done == 0) && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (bus_valid && nb < 2) begin
                gseq[nb] = bus_grant;
                sseq[nb] = bus_supplied;
                dseq[nb] = bus_data;
                nb++;
            end
            if (core_done[0]) begin c0done = cyc; core_req_valid[0] = 1'b0; end
            if (core_done[1]) begin c1done = cyc; core_req_valid[1] = 1'b0; end
        end
        chk(nb == 2, "R9", "contended transactions", nb, 2);
        chk(gseq[0] == 2'b01, "R9", "first grant", gseq[0], 2'b01);
        chk(gseq[1] == 2'b10, "R9", "second grant", gseq[1], 2'b10);
        chk(sseq[1] == 1'b1, "R7", "owner answers second ownership", sseq[1], 1);
        chk(dseq[1] == 8'h11, "R7", "owner data", dseq[1], 8'h11);
        chk(c1done == c0done + 1, "R11", "serialized completion", c1done, c0done + 1);
        // Model after contention: core0 invalidated, core1 modified with 0x22.
        mdl_st[1][1] = 2; mdl_tag[1][1] = 4'hB;
        mdl_inv[0][1] = 1'b1; mdl_tag[0][1] = 4'hB;
        golden[6'h2D] = 8'h22;
        run_op(0, 1'b0, 6'h2D, 8'h00);
        // Memory must be clean after the downgrade: both evict silently, reread from memory.
        run_op(0, 1'b0, 6'h01, 8'h00);
        run_op(1, 1'b0, 6'h01, 8'h00);
        run_op(0, 1'b0, 6'h2D, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule